// File: doc/BRIEF.md
# Input Clock Loss Monitor

This block watches an external input clock and reports whether it is present and fast enough. It runs from an internal reference clock that never stops. Rising edges of the input clock are counted in the input clock's own domain, and that count is carried into the reference domain as a Gray code. The reference side divides time into fixed windows of `WIN_LEN` reference cycles. In each window it takes the number of input edges and compares it with a programmable minimum.

After reset or a restart the monitor is in a qualifying phase. Two good windows in a row raise the `clk_valid` status. A single good window is not enough, so the flag does not flicker when the rate sits near the threshold. While the clock is valid, one bad window drops `clk_valid` and gives a one-cycle interrupt pulse. This covers a clock that has slowed and a clock that has stopped, because a stopped clock counts zero edges. The failure is latched and stays until software writes the restart bit.

The restart bit is a write strobe. It holds for one reference cycle, then clears itself. It clears the window timer and the qualification progress, and monitoring starts again. The rest of the clock system does not need a reset for this.

Top module: `oscwd_monitor`

## Requirements
- R1: While reset is applied and right after it is released, `clk_valid` is 0 and `fail_irq` is 0.
- R2: `clk_valid` becomes 1 only after two consecutive good windows. Each window is `WIN_LEN` reference cycles long. With the default `WIN_LEN`=32, the flag is still 0 about 48 cycles after a restart and is 1 by about 80 cycles after it.
- R3: A window is good when the number of input rising edges in it is greater than or equal to `min_edges`. The threshold is programmable: a rate of about 26 edges per window passes with `min_edges`=20 and fails with `min_edges`=30.
- R4: If the input clock stops while `clk_valid` is 1, `clk_valid` drops to 0 within two windows.
- R5: If the input clock becomes too slow (8 edges per window with `min_edges`=20) while `clk_valid` is 1, `clk_valid` drops to 0.
- R6: `fail_irq` is a pulse exactly one reference cycle wide. It occurs once on each change from valid to failed, in the same cycle that `clk_valid` falls. No pulse occurs while the monitor is qualifying and has never been valid.
- R7: A failure is latched. `clk_valid` stays 0 and no further pulse occurs after the input clock recovers, until a restart.
- R8: A one-cycle write of `restart_wr` clears the failure and the qualification progress without a reset. It produces no interrupt. It clears itself, so monitoring resumes and a good clock is qualified again as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_clk | input | 1 | Monitored input clock |
| min_edges | input | CNT_W | Minimum input rising edges per window for a good window |
| restart_wr | input | 1 | Software restart write strobe, reference domain |
| clk_valid | output | 1 | 1 when the input clock is qualified as present and fast enough |
| fail_irq | output | 1 | One-cycle interrupt request on a valid-to-failed change |

## Verification
A restart that is sampled at reference edge r clears the window timer at edge r+1. The window results then arrive at r+1+WIN_LEN and r+1+2·WIN_LEN, and `clk_valid` rises one edge later, at about r+2+2·WIN_LEN. The bench checks the flag at r+48 (still 0) and at r+80 (must be 1), both well away from that edge. The input clock is asynchronous and the synchronizer adds two or three cycles of latency, so failure checks are made two to three full windows after the stimulus. Interrupt pulses are counted on every falling reference edge, together with any pulse longer than one cycle. Each scenario compares the change in these counts with the expected number of pulses.

// File: rtl/oscwd_pkg.sv
package oscwd_pkg;

  // Qualification state of the monitor
  typedef enum logic [1:0] {
    ST_QUAL = 2'd0,  // counting good windows, not yet valid
    ST_GOOD = 2'd1,  // input clock qualified
    ST_FAIL = 2'd2   // latched failure, waits for restart
  } wd_state_e;

endpackage

// File: rtl/oscwd_rst_sync.sv
module oscwd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  // asynchronous assert, release after two edges of clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/oscwd_gray_cnt.sv
module oscwd_gray_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray_o
);
  logic [CNT_W-1:0] bin_q, bin_d;
  logic [CNT_W-1:0] gray_q, gray_d;

  always_comb begin
    bin_d  = bin_q + 1'b1;
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign gray_o = gray_q;
endmodule

// File: rtl/oscwd_window.sv
module oscwd_window #(
  parameter int CNT_W   = 8,
  parameter int WIN_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_async,
  input  logic [CNT_W-1:0] min_edges,
  input  logic             restart,
  output logic             win_done,
  output logic             win_ok
);
  localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

  logic [CNT_W-1:0] meta_q, sync_q;
  logic [CNT_W-1:0] cur_bin;
  logic [CNT_W-1:0] base_q, base_d;
  logic [CNT_W-1:0] delta;
  logic [WIN_W-1:0] tick_q, tick_d;
  logic             done_q, done_d;
  logic             ok_q, ok_d;

  // two-stage synchronizer; Gray code changes one bit per input edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_async;
      sync_q <= meta_q;
    end
  end

  // Gray to binary, most significant bit first
  always_comb begin
    cur_bin[CNT_W-1] = sync_q[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      cur_bin[i] = cur_bin[i+1] ^ sync_q[i];
    end
  end

  assign delta = cur_bin - base_q;

  always_comb begin
    tick_d = tick_q + 1'b1;
    base_d = base_q;
    done_d = 1'b0;
    ok_d   = ok_q;
    if (restart) begin
      tick_d = '0;
      base_d = cur_bin;
    end else if (tick_q == WIN_LAST) begin
      tick_d = '0;
      base_d = cur_bin;
      done_d = 1'b1;
      ok_d   = (delta >= min_edges);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      base_q <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      tick_q <= tick_d;
      base_q <= base_d;
      done_q <= done_d;
      ok_q   <= ok_d;
    end
  end

  assign win_done = done_q;
  assign win_ok   = ok_q;
endmodule

// File: rtl/oscwd_status.sv
module oscwd_status
  import oscwd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart_wr,
  input  logic win_done,
  input  logic win_ok,
  output logic restart_o,
  output logic failed_o,
  output logic clk_valid,
  output logic fail_irq
);
  wd_state_e state_q, state_d;
  logic      streak_q, streak_d;
  logic      restart_q;
  logic      irq_q, irq_d;
  logic      valid_q;

  always_comb begin
    state_d  = state_q;
    streak_d = streak_q;
    irq_d    = 1'b0;
    if (restart_q) begin
      state_d  = ST_QUAL;
      streak_d = 1'b0;
    end else if (win_done) begin
      unique case (state_q)
        ST_QUAL: begin
          if (!win_ok) begin
            streak_d = 1'b0;
          end else if (streak_q) begin
            state_d  = ST_GOOD;
            streak_d = 1'b0;
          end else begin
            streak_d = 1'b1;
          end
        end
        ST_GOOD: begin
          if (!win_ok) begin
            state_d = ST_FAIL;
            irq_d   = 1'b1;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  // restart bit reads one for a single cycle after a write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restart_q <= 1'b0;
      state_q   <= ST_QUAL;
      streak_q  <= 1'b0;
      irq_q     <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      restart_q <= restart_wr;
      state_q   <= state_d;
      streak_q  <= streak_d;
      irq_q     <= irq_d;
      valid_q   <= (state_d == ST_GOOD);
    end
  end

  assign restart_o = restart_q;
  assign failed_o  = (state_q == ST_FAIL);
  assign clk_valid = valid_q;
  assign fail_irq  = irq_q;
endmodule

// File: rtl/oscwd_monitor.sv
module oscwd_monitor #(
  parameter int CNT_W   = 8,
  parameter int WIN_LEN = 32
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             in_clk,
  input  logic [CNT_W-1:0] min_edges,
  input  logic             restart_wr,
  output logic             clk_valid,
  output logic             fail_irq
);
  logic             rst_ref_n;
  logic             rst_in_n;
  logic [CNT_W-1:0] in_gray;
  logic             restart_q;
  logic             win_done;
  logic             win_ok;
  logic             failed;

  oscwd_rst_sync u_rst_ref (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ref_n)
  );

  oscwd_rst_sync u_rst_in (
    .clk        (in_clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_in_n)
  );

  oscwd_gray_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (in_clk),
    .rst_n  (rst_in_n),
    .gray_o (in_gray)
  );

  oscwd_window #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN)) u_win (
    .clk        (ref_clk),
    .rst_n      (rst_ref_n),
    .gray_async (in_gray),
    .min_edges  (min_edges),
    .restart    (restart_q),
    .win_done   (win_done),
    .win_ok     (win_ok)
  );

  oscwd_status u_stat (
    .clk        (ref_clk),
    .rst_n      (rst_ref_n),
    .restart_wr (restart_wr),
    .win_done   (win_done),
    .win_ok     (win_ok),
    .restart_o  (restart_q),
    .failed_o   (failed),
    .clk_valid  (clk_valid),
    .fail_irq   (fail_irq)
  );
endmodule

// File: rtl/oscwd_monitor_chk.sv
module oscwd_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic clk_valid,
  input logic fail_irq,
  input logic win_done,
  input logic win_ok,
  input logic restart_q,
  input logic failed
);
  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_irq |=> !fail_irq);

  // R6
  irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_irq |-> (!clk_valid && $past(clk_valid)));

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_valid) |-> $past(win_done && win_ok && !restart_q));

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |=> (!clk_valid && !fail_irq));

  // R7
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (failed && !restart_q) |=> (failed && !clk_valid));

  // R4
  bad_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_valid && win_done && !win_ok && !restart_q) |=> fail_irq);
endmodule

bind oscwd_monitor oscwd_monitor_chk u_chk (
  .clk       (ref_clk),
  .rst_n     (rst_ref_n),
  .clk_valid (clk_valid),
  .fail_irq  (fail_irq),
  .win_done  (win_done),
  .win_ok    (win_ok),
  .restart_q (restart_q),
  .failed    (failed)
);

// File: tb/oscwd_monitor_tb.sv
`timescale 1ns/1ps
module oscwd_monitor_tb;
  localparam int CNT_W = 8;

  logic             ref_clk;
  logic             rst_n;
  logic             in_clk;
  logic [CNT_W-1:0] min_edges;
  logic             restart_wr;
  logic             clk_valid;
  logic             fail_irq;

  int    n_total;
  int    n_bad;
  int    irq_cnt;
  int    irq_long;
  logic  irq_prev;
  logic  in_run;
  real   in_half;
  logic  done;

  oscwd_monitor #(.CNT_W(CNT_W), .WIN_LEN(32)) u_dut (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .in_clk     (in_clk),
    .min_edges  (min_edges),
    .restart_wr (restart_wr),
    .clk_valid  (clk_valid),
    .fail_irq   (fail_irq)
  );

  initial ref_clk = 1'b0;
  always #5 ref_clk = ~ref_clk;

  initial in_clk = 1'b0;
  always begin
    if (in_run) begin
      #(in_half) in_clk = ~in_clk;
    end else begin
      #1;
    end
  end

  // interrupt pulse bookkeeping, sampled away from the active edge
  always @(negedge ref_clk) begin
    if (fail_irq) irq_cnt = irq_cnt + 1;
    if (fail_irq && irq_prev) irq_long = irq_long + 1;
    irq_prev = fail_irq;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic pulse_restart();
    @(negedge ref_clk);
    restart_wr = 1'b1;
    @(negedge ref_clk);
    restart_wr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wait_cyc(5);
    chk("R1 valid in reset", int'(clk_valid), 0);
    chk("R1 irq in reset", int'(fail_irq), 0);
    rst_n = 1'b1;
    wait_cyc(4);
    chk("R1 valid after release", int'(clk_valid), 0);
    chk("R1 irq after release", irq_cnt, 0);
  endtask

  task automatic t_qualify();
    int base;
    in_half = 2.0; in_run = 1'b1; min_edges = 8'd20;
    base = irq_cnt;
    pulse_restart();
    wait_cyc(47);
    chk("R2 one good window not enough", int'(clk_valid), 0);
    wait_cyc(32);
    chk("R2 valid after two good windows", int'(clk_valid), 1);
    chk("R8 restart gives no irq", irq_cnt - base, 0);
  endtask

  task automatic t_stop();
    int base;
    base = irq_cnt;
    in_run = 1'b0;
    wait_cyc(100);
    chk("R4 valid after stop", int'(clk_valid), 0);
    chk("R6 one irq on stop", irq_cnt - base, 1);
    in_run = 1'b1;
    wait_cyc(130);
    chk("R7 latched after recovery", int'(clk_valid), 0);
    chk("R7 no extra irq", irq_cnt - base, 1);
  endtask

  task automatic t_restart();
    int base;
    base = irq_cnt;
    pulse_restart();
    wait_cyc(79);
    chk("R8 requalified after restart", int'(clk_valid), 1);
    chk("R8 no irq from restart", irq_cnt - base, 0);
  endtask

  task automatic t_slow();
    int base;
    base = irq_cnt;
    in_half = 20.0;
    wait_cyc(100);
    chk("R5 valid after slowdown", int'(clk_valid), 0);
    chk("R5 irq after slowdown", irq_cnt - base, 1);
  endtask

  task automatic t_threshold();
    int base;
    in_half = 6.0; min_edges = 8'd20;
    pulse_restart();
    wait_cyc(100);
    chk("R3 26 edges pass min 20", int'(clk_valid), 1);
    base = irq_cnt;
    min_edges = 8'd30;
    wait_cyc(80);
    chk("R3 26 edges fail min 30", int'(clk_valid), 0);
    chk("R3 irq on threshold fail", irq_cnt - base, 1);
  endtask

  task automatic t_never_valid();
    int base;
    in_half = 20.0; min_edges = 8'd20;
    base = irq_cnt;
    pulse_restart();
    wait_cyc(160);
    chk("R6 slow clock never valid", int'(clk_valid), 0);
    chk("R6 no irq while qualifying", irq_cnt - base, 0);
  endtask

  initial begin
    done = 1'b0;
    #2_000_000;
    if (!done) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    n_total = 0; n_bad = 0; irq_cnt = 0; irq_long = 0; irq_prev = 1'b0;
    in_run = 1'b1; in_half = 2.0;
    rst_n = 1'b0; restart_wr = 1'b0; min_edges = 8'd20;
    t_reset();
    t_qualify();
    t_stop();
    t_restart();
    t_slow();
    t_threshold();
    t_never_valid();
    chk("R6 irq pulse width one cycle", irq_long, 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule